// File: doc/BRIEF.md
# Memory-Mapped SPI NOR Flash Controller

This controller connects a simple request/ready host bus to a single SPI NOR flash device on one chip select, using single-bit SPI mode 0. The host reaches it through two windows, and `bus_sel` picks one of them. The register window holds three 32-bit registers: configuration, addressing and control. The flash window carries the flash traffic.

In user mode, software frames the chip select by hand through a control bit. Each access to the flash window then becomes a raw SPI transfer. A byte access moves one byte and a word access moves four bytes. Reads return what was clocked in on MISO.

In the three direct modes, the controller turns every flash-window access into a complete SPI transaction on its own. It sends an opcode taken from the control register, then a 3-byte or 4-byte address, then any dummy byte, then four data bytes, all inside one chip-select frame. The host bus is held with `bus_ready` low until the transfer has finished.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset all three registers read 0, so the controller is in normal read mode. `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: The register window has three registers, each of which reads back its last written 32-bit value:
  - configuration at offset 0x00;
  - addressing at offset 0x04;
  - control at offset 0x10.
  Any other offset reads 0.
- R3: Control bits 1:0 select the mode: 0 is normal read, 1 is fast read, 2 is write and 3 is user. In user mode `spi_cs_n` equals control bit 2. Writing mode 3 with bit 2 set and then clearing bit 2 opens a frame, and setting bit 2 again closes it.
- R4: In user mode, a byte write shifts `bus_wdata[7:0]` out on MOSI, and a word write shifts four bytes out, most significant byte first. SCK idles low. MOSI is stable when SCK rises (mode 0).
- R5: In user mode, a byte read returns the received byte in bits 7:0, with zeros above it. A word read returns four received bytes, the first in bits 31:24. The frame stays open across accesses, so successive reads continue the byte stream. Reads send 0x00 on MOSI.
- R6: In normal read mode, a flash-window read sends the following inside one chip-select frame, and returns the four data bytes with the first in bits 31:24:
  - the opcode in control bits 23:16;
  - address bits 23:0, most significant byte first;
  - four 0x00 bytes, during which data is read in.
- R7: When addressing register bit 0 is set, direct modes send all 32 address bits (4 bytes) in place of 3.
- R8: Fast read mode (1) inserts one 0x00 byte (8 dummy clocks) between the address and the data.
- R9: In write mode (2) with writes enabled, a flash-window write sends the opcode, then the address, then `bus_wdata` most significant byte first. Flash-window writes in modes 0 and 1 complete with no SCK activity.
- R10: While configuration bit 16 is clear, every flash-window write completes with `bus_ready` and no SCK edge, in every mode.
- R11: The SCK period is `CLK_DIV` clocks. A flash access raises `bus_ready` for exactly one cycle, one cycle after the final SCK falling edge. A register access raises it one cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request; held until `bus_ready` is seen |
| bus_sel | input | 1 | Window select: 0 selects registers, 1 selects flash |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_word | input | 1 | 1 for a 32-bit access, 0 for a byte access |
| bus_addr | input | AW | Register offset or flash-window offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A register access is due one cycle after the request is accepted. A flash access is due one cycle after the last SCK falling edge, and each byte takes `8*CLK_DIV` clocks plus two launch cycles.

The bench counts clocks at the falling clock edge. It logs the cycle of every SCK rising and falling edge and of `bus_ready`. It then compares the ready cycle with the final SCK fall, and the gap between SCK rises with `CLK_DIV`.

Wire bytes are checked as they arrive, against a queue the driver fills before each access. Read data is compared once the bus handshake has ended.

// File: rtl/sfc_pkg.sv
// Shared types for the SPI flash controller.
// Assumes: at most ten wire bytes per transaction
// (opcode + 4 address + dummy + 4 data).
package sfc_pkg;
    typedef enum logic [1:0] {
        MD_READ  = 2'd0,
        MD_FAST  = 2'd1,
        MD_WRITE = 2'd2,
        MD_USER  = 2'd3
    } sfc_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_DONE = 2'd2
    } sfc_state_e;

    localparam int unsigned MAX_BYTES = 10;
endpackage

// File: rtl/sfc_regs.sv
// Register window of the SPI flash controller.
// Holds the configuration, addressing and control registers and splits out
// the fields the sequencer needs.
// Assumes: writes arrive as a one-cycle strobe; unmapped offsets read 0.
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rd_data,
    output sfc_mode_e       mode,
    output logic [7:0]      opcode,
    output logic            cs_stop,
    output logic            addr4,
    output logic            wr_en
);
    localparam logic [AW-1:0] OFS_CONF  = AW'(32'h00);
    localparam logic [AW-1:0] OFS_ADDR  = AW'(32'h04);
    localparam logic [AW-1:0] OFS_CTRL  = AW'(32'h10);
    localparam int            WEN_BIT   = 16;
    localparam int            STOP_BIT  = 2;
    localparam int            OP_LSB    = 16;

    logic [31:0] conf_q, addr_q, ctrl_q;

    // Register storage: each register takes the full word on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conf_q <= '0;
            addr_q <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            if (addr == OFS_CONF) conf_q <= wdata;
            if (addr == OFS_ADDR) addr_q <= wdata;
            if (addr == OFS_CTRL) ctrl_q <= wdata;
        end
    end

    // Read mux: stored values for mapped offsets, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (addr == OFS_CONF) rd_data = conf_q;
        if (addr == OFS_ADDR) rd_data = addr_q;
        if (addr == OFS_CTRL) rd_data = ctrl_q;
    end

    assign mode    = sfc_mode_e'(ctrl_q[1:0]);
    assign opcode  = ctrl_q[OP_LSB +: 8];
    assign cs_stop = ctrl_q[STOP_BIT];
    assign addr4   = addr_q[0];
    assign wr_en   = conf_q[WEN_BIT];

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctrl_q) && $stable(conf_q) && $stable(addr_q)); // R2
endmodule

// File: rtl/sfc_shift.sv
// SPI mode 0 byte engine.
// Shifts one byte out on MOSI, most significant bit first, and samples MISO
// on each SCK rise.
// Assumes: CLK_DIV is even and at least 2; start only arrives while idle.
module sfc_shift #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = $clog2(HALF + 1);

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    // Bit timing: each SCK phase lasts HALF clocks.
    // Sample on the rise, shift on the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sck  <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            rx   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                sh   <= tx;
                cnt  <= '0;
                bitn <= '0;
                sck  <= 1'b0;
            end else if (busy) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[6:0], miso};
                    end else begin
                        sck  <= 1'b0;
                        sh   <= {sh[6:0], 1'b0};
                        bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign mosi = sh[7];

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck); // R4
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sck && $past(sck))); // R11
endmodule

// File: rtl/sfc_seq.sv
// Transaction sequencer.
// Accepts one bus access at a time and builds the whole wire byte string for
// it. Hands those bytes to the byte engine one by one, collects the received
// bytes, and drives chip select and the ready pulse.
// Assumes: the host holds the request and its fields stable until ready.
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic            bus_word,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    input  logic [31:0]     reg_rd,
    input  sfc_mode_e       mode,
    input  logic [7:0]      opcode,
    input  logic            cs_stop,
    input  logic            addr4,
    input  logic            wr_en,
    input  logic            eng_busy,
    input  logic            eng_done,
    input  logic [7:0]      eng_rx,
    output logic            reg_wr,
    output logic            eng_start,
    output logic [7:0]      eng_tx,
    output logic            bus_ready,
    output logic [31:0]     bus_rdata,
    output logic            cs_n
);
    localparam int VW = 8 * MAX_BYTES;
    localparam int NW = $clog2(MAX_BYTES + 1);

    sfc_state_e      st;
    logic [VW-1:0]   tx_q, pl_vec;
    logic [NW-1:0]   left, pl_n;
    logic            pl_drop, start_q, dir_q;
    logic [23:0]     rx_acc;
    logic [31:0]     rdata_q, fa;

    assign fa = 32'(bus_addr);

    // Plan: the left-aligned byte string, its length, and whether the access is dropped.
    always_comb begin
        pl_vec  = '0;
        pl_n    = '0;
        pl_drop = 1'b0;
        if (mode == MD_USER) begin
            pl_drop = bus_we && !wr_en;
            pl_n    = bus_word ? NW'(4) : NW'(1);
            if (bus_we)
                pl_vec[VW-1 -: 32] = bus_word ? bus_wdata : {bus_wdata[7:0], 24'h0};
        end else if (bus_we) begin
            pl_drop = (mode != MD_WRITE) || !wr_en;
            if (addr4) begin
                pl_vec[VW-1 -: 72] = {opcode, fa, bus_wdata};
                pl_n = NW'(9);
            end else begin
                pl_vec[VW-1 -: 64] = {opcode, fa[23:0], bus_wdata};
                pl_n = NW'(8);
            end
        end else begin
            if (addr4) begin
                pl_vec[VW-1 -: 40] = {opcode, fa};
                pl_n = NW'(9);
            end else begin
                pl_vec[VW-1 -: 32] = {opcode, fa[23:0]};
                pl_n = NW'(8);
            end
            if (mode == MD_FAST) pl_n = pl_n + NW'(1);
        end
    end

    // Access state machine: accept, stream the bytes, then pulse ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            tx_q    <= '0;
            left    <= '0;
            start_q <= 1'b0;
            dir_q   <= 1'b0;
            rx_acc  <= '0;
            rdata_q <= '0;
        end else begin
            start_q <= 1'b0;
            case (st)
                SQ_IDLE: if (bus_req) begin
                    if (!bus_sel) begin
                        rdata_q <= bus_we ? 32'h0 : reg_rd;
                        st      <= SQ_DONE;
                    end else if (pl_drop) begin
                        rdata_q <= '0;
                        st      <= SQ_DONE;
                    end else begin
                        tx_q    <= pl_vec;
                        left    <= pl_n;
                        start_q <= 1'b1;
                        dir_q   <= (mode != MD_USER);
                        rx_acc  <= '0;
                        st      <= SQ_XFER;
                    end
                end
                SQ_XFER: if (eng_done) begin
                    rx_acc <= {rx_acc[15:0], eng_rx};
                    if (left == NW'(1)) begin
                        rdata_q <= bus_we ? 32'h0 : {rx_acc, eng_rx};
                        dir_q   <= 1'b0;
                        st      <= SQ_DONE;
                    end else begin
                        left    <= left - NW'(1);
                        tx_q    <= {tx_q[VW-9:0], 8'h00};
                        start_q <= 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign reg_wr    = (st == SQ_IDLE) && bus_req && !bus_sel && bus_we;
    assign eng_start = start_q;
    assign eng_tx    = tx_q[VW-1 -: 8];
    assign bus_ready = (st == SQ_DONE);
    assign bus_rdata = rdata_q;
    assign cs_n      = (mode == MD_USER) ? cs_stop : !dir_q;

    AST_GATE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE && bus_req && bus_sel && bus_we && !wr_en)
        |=> (st == SQ_DONE && !start_q)); // R10
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready); // R11
    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !eng_busy); // R11
endmodule

// File: rtl/spi_flash_ctl.sv
// Top level of the memory-mapped SPI NOR flash controller.
// Wires the register window, the transaction sequencer and the SPI byte
// engine together.
// Assumes: single chip select, single-bit SPI mode 0, CLK_DIV even and >= 2.
module spi_flash_ctl
    import sfc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CLK_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic            bus_word,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            bus_ready,
    output logic            spi_sck,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    input  logic            spi_miso
);
    logic [31:0] reg_rd;
    sfc_mode_e   mode;
    logic [7:0]  opcode, eng_tx, eng_rx;
    logic        cs_stop, addr4, wr_en, reg_wr;
    logic        eng_start, eng_busy, eng_done;

    sfc_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rd_data(reg_rd), .mode(mode), .opcode(opcode), .cs_stop(cs_stop),
        .addr4(addr4), .wr_en(wr_en)
    );

    sfc_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .reg_rd(reg_rd), .mode(mode), .opcode(opcode),
        .cs_stop(cs_stop), .addr4(addr4), .wr_en(wr_en), .eng_busy(eng_busy),
        .eng_done(eng_done), .eng_rx(eng_rx), .reg_wr(reg_wr),
        .eng_start(eng_start), .eng_tx(eng_tx), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .cs_n(spi_cs_n)
    );

    sfc_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(eng_tx), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi), .busy(eng_busy), .done(eng_done), .rx(eng_rx)
    );

    AST_DIRECT_CS_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_USER && spi_sck) |-> !spi_cs_n); // R6
endmodule

// File: tb/sim_spi_flash_ctl.sv
`timescale 1ns/1ps
module sim_spi_flash_ctl;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_sel = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        bus_ready, spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #2 clk = ~clk;

    spi_flash_ctl #(.AW(32), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0, fall_cyc = 0, rise_cyc = 0, rise_gap = 0, rdy_cyc = 0, n_rise = 0;
    logic prev_sck = 1'b0;
    logic [7:0] exp_q[$];
    string cur_req = "R4";
    int fbit = 0, fbyte = 0;
    logic [7:0] mosi_sh = '0, miso_byte;

    function automatic logic [7:0] pat(input int b);
        return 8'hC3 ^ 8'(b * 29);
    endfunction

    // Flash model: the byte pattern depends on the position within the frame.
    always_comb miso_byte = pat(fbyte);
    assign spi_miso = miso_byte[3'(7 - fbit)];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: frame reset on CS fall; byte capture on SCK rise, popped against the queue.
    always @(negedge spi_cs_n or posedge spi_sck) begin
        if (!spi_sck) begin
            fbit = 0;
            fbyte = 0;
        end else begin
            mosi_sh = {mosi_sh[6:0], spi_mosi};
            if (fbit == 7) begin
                fbit = 0;
                fbyte++;
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL %s unexpected wire byte actual=%h expected=none", cur_req, mosi_sh);
                end else begin
                    check({cur_req, " wire byte"}, {24'h0, mosi_sh}, {24'h0, exp_q.pop_front()});
                end
            end else begin
                fbit++;
            end
        end
    end

    // Cycle log and watchdog, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (prev_sck && !spi_sck) fall_cyc = cyc;
        if (!prev_sck && spi_sck) begin
            rise_gap = cyc - rise_cyc;
            rise_cyc = cyc;
            n_rise++;
        end
        if (bus_ready) rdy_cyc = cyc;
        prev_sck = spi_sck;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Driver: one bus access with the hold-until-ready handshake.
    task automatic xfer(input logic sel, input logic we, input logic word,
                        input logic [31:0] addr, input logic [31:0] wdata,
                        output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_sel = sel; bus_we = we; bus_word = word;
        bus_addr = addr; bus_wdata = wdata;
        waits = 0;
        forever begin
            @(negedge clk);
            waits++;
            if (bus_ready) break;
        end
        rd = bus_rdata;
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [31:0] ofs, input logic [31:0] val);
        logic [31:0] d; int w;
        xfer(1'b0, 1'b1, 1'b1, ofs, val, d, w);
    endtask

    task automatic reg_rd(input logic [31:0] ofs, output logic [31:0] val);
        int w;
        xfer(1'b0, 1'b0, 1'b1, ofs, 32'h0, val, w);
    endtask

    task automatic push4(input logic [31:0] v);
        exp_q.push_back(v[31:24]); exp_q.push_back(v[23:16]);
        exp_q.push_back(v[15:8]);  exp_q.push_back(v[7:0]);
    endtask

    function automatic logic [31:0] pat4(input int b);
        return {pat(b), pat(b + 1), pat(b + 2), pat(b + 3)};
    endfunction

    initial begin
        logic [31:0] d;
        int w, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 cs_n", {31'h0, spi_cs_n}, 32'h1);
        check("R1 sck", {31'h0, spi_sck}, 32'h0);
        reg_rd(32'h00, d); check("R1 conf", d, 32'h0);
        reg_rd(32'h04, d); check("R1 addressing", d, 32'h0);
        xfer(1'b0, 1'b0, 1'b1, 32'h10, 32'h0, d, w);
        check("R1 control", d, 32'h0);
        check("R11 register ready latency", w, 1);

        // R2: register read-back
        reg_wr(32'h10, 32'h00AB_0004); reg_rd(32'h10, d); check("R2 control", d, 32'h00AB_0004);
        reg_wr(32'h04, 32'h0000_0001); reg_rd(32'h04, d); check("R2 addressing", d, 32'h1);
        reg_wr(32'h00, 32'h5A01_0000); reg_rd(32'h00, d); check("R2 conf", d, 32'h5A01_0000);
        reg_rd(32'h08, d); check("R2 unmapped", d, 32'h0);
        reg_wr(32'h04, 32'h0);
        reg_wr(32'h00, 32'h0);

        // R3: user-mode framing, R10: write gate with enable clear
        reg_wr(32'h10, 32'h7);
        check("R3 cs_n with stop set", {31'h0, spi_cs_n}, 32'h1);
        reg_wr(32'h10, 32'h3);
        check("R3 cs_n opened", {31'h0, spi_cs_n}, 32'h0);
        r0 = n_rise;
        xfer(1'b1, 1'b1, 1'b0, 32'h0, 32'h06, d, w);
        check("R10 no SCK in user write", n_rise - r0, 0);

        // R4: user writes, frame position 0..4
        reg_wr(32'h00, 32'h0001_0000);
        cur_req = "R4";
        exp_q.push_back(8'hB7);
        xfer(1'b1, 1'b1, 1'b0, 32'h0, 32'hFFFF_FFB7, d, w);
        push4(32'h1234_5678);
        xfer(1'b1, 1'b1, 1'b1, 32'h0, 32'h1234_5678, d, w);
        check("R11 SCK period", rise_gap, DIV);
        check("R11 ready after last fall", rdy_cyc - fall_cyc, 1);

        // R5: user reads continue the stream at positions 5 and 6..9
        cur_req = "R5";
        exp_q.push_back(8'h00);
        xfer(1'b1, 1'b0, 1'b0, 32'h0, 32'h0, d, w);
        check("R5 byte read", d, {24'h0, pat(5)});
        push4(32'h0);
        xfer(1'b1, 1'b0, 1'b1, 32'h0, 32'h0, d, w);
        check("R5 word read", d, pat4(6));
        reg_wr(32'h10, 32'h7);
        check("R3 cs_n closed", {31'h0, spi_cs_n}, 32'h1);

        // R6: normal read, 3-byte address
        cur_req = "R6";
        reg_wr(32'h10, 32'h0003_0000);
        exp_q.push_back(8'h03); exp_q.push_back(8'h12);
        exp_q.push_back(8'h34); exp_q.push_back(8'h56);
        push4(32'h0);
        xfer(1'b1, 1'b0, 1'b1, 32'h0012_3456, 32'h0, d, w);
        check("R6 read data", d, pat4(4));
        check("R11 ready after last fall", rdy_cyc - fall_cyc, 1);
        check("R6 cs_n released", {31'h0, spi_cs_n}, 32'h1);

        // R7: 4-byte address
        cur_req = "R7";
        reg_wr(32'h04, 32'h1);
        push4(32'h0302_3456); exp_q.push_back(8'h78);
        push4(32'h0);
        xfer(1'b1, 1'b0, 1'b1, 32'h0234_5678, 32'h0, d, w);
        check("R7 read data", d, pat4(5));

        // R8: fast read with dummy byte, 3-byte address
        cur_req = "R8";
        reg_wr(32'h04, 32'h0);
        reg_wr(32'h10, 32'h000B_0001);
        push4(32'h0B00_A0C4); exp_q.push_back(8'h00);
        push4(32'h0);
        xfer(1'b1, 1'b0, 1'b1, 32'h0000_A0C4, 32'h0, d, w);
        check("R8 read data", d, pat4(5));

        // R9: write dropped in fast read mode even with enable set
        r0 = n_rise;
        xfer(1'b1, 1'b1, 1'b1, 32'h100, 32'h1111_2222, d, w);
        check("R9 no SCK in read-mode write", n_rise - r0, 0);

        // R9: direct write, 4-byte address
        cur_req = "R9";
        reg_wr(32'h04, 32'h1);
        reg_wr(32'h10, 32'h0002_0002);
        push4(32'h0200_0001); exp_q.push_back(8'h00);
        push4(32'hDEAD_BEEF);
        xfer(1'b1, 1'b1, 1'b1, 32'h0000_0100, 32'hDEAD_BEEF, d, w);
        check("R11 ready after last fall", rdy_cyc - fall_cyc, 1);

        // R10: direct write with enable cleared
        reg_wr(32'h00, 32'h0);
        r0 = n_rise;
        xfer(1'b1, 1'b1, 1'b1, 32'h200, 32'h3333_4444, d, w);
        check("R10 no SCK in direct write", n_rise - r0, 0);
        check("R10 cs_n idle", {31'h0, spi_cs_n}, 32'h1);

        check("R4 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule